// File: doc/BRIEF.md
# Battery Full-Capacity Learning Controller

This block holds the learned full-capacity figure of a rechargeable battery gauge and adjusts it from what the battery actually delivers. A discharge can teach a new capacity only if it starts with the gauge full, meaning the available capacity equals the learned value. It must then reach end of discharge with the temperature at or above 0 °C, with the self-discharge reduction within 6 %, and with no valid charge in between. Such a discharge sets the qualification flag. The next valid charge then copies the measured discharge count into the learned register. A downward step is limited to 241/256 (about 0.94) of the previous value.

Every valid charge that does not update the learned value adds one to a saturating counter, which shows how stale the capacity figure is. The surrounding gauge supplies the measured count and the available capacity. It also supplies the qualification inputs and one-cycle event strobes, and it reads the learned value and the flags back.

Top module: `cap_learn`

## Requirements
- R1: While `rst_n` is low at a rising edge, `learned_cap` loads `prog_cap`, and `chg_flag`, `qual_flag` and `miss_cnt` go to 0.
- R2: A `chg_ok` pulse that arrives after an `empty_hit` while `qual_flag` is 1 sets `learned_cap` to `meas_cap` on that edge, provided `meas_cap` is not below the floor of R3. It also clears `miss_cnt` to 0. The learned value may rise as well as fall.
- R3: When an update would take `learned_cap` below floor(`learned_cap`·241/256), `learned_cap` takes that floor instead.
- R4: A `dsg_go` pulse while `avail_cap` equals `learned_cap` clears `chg_flag` and sets `qual_flag` to `temp_ok & sdr_ok`. A `dsg_go` pulse while they differ changes neither flag.
- R5: Every `chg_ok` pulse sets `chg_flag` to 1.
- R6: Before end of discharge, any cycle with `temp_ok` low, with `sdr_ok` low, or with a `chg_ok` pulse clears `qual_flag`. A flag that is cleared stays 0 until the next discharge start from full.
- R7: A `chg_ok` pulse that does not update `learned_cap` increments `miss_cnt`, which stops at 255.
- R8: `learned_cap` changes only on reset or on a `chg_ok` pulse.
- R9: A `chg_ok` pulse takes priority. A `dsg_go` or `empty_hit` in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the programmed capacity |
| prog_cap | input | 16 | Programmed full-capacity value |
| meas_cap | input | 16 | Measured discharge count from full to empty |
| avail_cap | input | 16 | Nominal available capacity |
| chg_ok | input | 1 | One-cycle strobe: valid charge detected |
| dsg_go | input | 1 | One-cycle strobe: discharge starts |
| empty_hit | input | 1 | One-cycle strobe: end-of-discharge threshold reached |
| temp_ok | input | 1 | Temperature at or above 0 °C |
| sdr_ok | input | 1 | Self-discharge reduction within 6 % |
| learned_cap | output | 16 | Learned full-capacity register |
| chg_flag | output | 1 | Valid charge seen since the last discharge from full |
| qual_flag | output | 1 | Current discharge still qualifies for learning |
| miss_cnt | output | 8 | Charges made without a capacity update |

## Verification
The bench builds the block with its defaults: 16-bit capacities, an 8-bit miss counter and the 241/256 floor factor. With those values the floor rounding can be checked on ordinary numbers, for example 980 down to 922. Counter saturation at 255 is reached with a few hundred charge pulses. The run covers learning upward and downward, disqualification by each input, discharge starts when the gauge is not full, and strobe collisions.

// File: rtl/cap_learn.sv
module cap_learn #(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  parameter int FNUM  = 241,
  parameter int FSH   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     prog_cap,
  input  logic [W-1:0]     meas_cap,
  input  logic [W-1:0]     avail_cap,
  input  logic             chg_ok,
  input  logic             dsg_go,
  input  logic             empty_hit,
  input  logic             temp_ok,
  input  logic             sdr_ok,
  output logic [W-1:0]     learned_cap,
  output logic             chg_flag,
  output logic             qual_flag,
  output logic [CNT_W-1:0] miss_cnt
);

  localparam int PW = W + FSH;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic          empty_q;
  logic [PW-1:0] prod;
  logic [W-1:0]  floor_v;
  logic [W-1:0]  next_cap;
  logic          at_full, cond_ok, learn_go;

  assign prod     = PW'(learned_cap) * PW'(FNUM);
  assign floor_v  = prod[PW-1:FSH];
  assign next_cap = (meas_cap < floor_v) ? floor_v : meas_cap;
  assign at_full  = (avail_cap == learned_cap);
  assign cond_ok  = temp_ok & sdr_ok;
  assign learn_go = chg_ok & empty_q & qual_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      learned_cap <= prog_cap;
      chg_flag    <= 1'b0;
      qual_flag   <= 1'b0;
      empty_q     <= 1'b0;
      miss_cnt    <= '0;
    end else if (chg_ok) begin
      chg_flag  <= 1'b1;
      qual_flag <= 1'b0;
      empty_q   <= 1'b0;
      if (learn_go) begin
        learned_cap <= next_cap;
        miss_cnt    <= '0;
      end else if (miss_cnt != CNT_MAX) begin
        miss_cnt <= miss_cnt + 1'b1;
      end
    end else if (dsg_go && at_full) begin
      chg_flag  <= 1'b0;
      qual_flag <= cond_ok;
      empty_q   <= 1'b0;
    end else begin
      if (!empty_q) qual_flag <= qual_flag & cond_ok;
      if (empty_hit) empty_q <= 1'b1;
    end
  end

  p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(learn_go) && ($past(meas_cap) >= $past(floor_v))
      |-> learned_cap == $past(meas_cap));

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> learned_cap >= $past(floor_v));

  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dsg_go && at_full && !chg_ok) |-> !chg_flag);

  p_vq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(chg_ok) |-> chg_flag);

  p_dq_temp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(temp_ok) && !$past(empty_q) |-> !qual_flag);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (miss_cnt == '0) || (miss_cnt == $past(miss_cnt))
                     || (miss_cnt == $past(miss_cnt) + 1'b1));

  p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(miss_cnt) == CNT_MAX) && !$past(learn_go)
      |-> miss_cnt == CNT_MAX);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(chg_ok) |-> $stable(learned_cap));

endmodule

// File: tb/cap_learn_test.sv
module cap_learn_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        rst;
    logic        vc;
    logic        ds;
    logic        eod;
    logic        tok;
    logic        sok;
    logic [15:0] meas;
    logic [15:0] avail;
    logic [15:0] e_cap;
    logic        e_vq;
    logic        e_dq;
    logic [7:0]  e_cnt;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'd0,   16'd0,   16'd1000,1'b0,1'b0,8'd0,"R1"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd1000,16'd1000,1'b0,1'b1,8'd0,"R4"},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'd0,   16'd1000,16'd1000,1'b0,1'b1,8'd0,"R6"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd980, 16'd0,   16'd980, 1'b1,1'b0,8'd0,"R2"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd980, 16'd980, 1'b0,1'b1,8'd0,"R4"},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'd0,   16'd0,   16'd980, 1'b0,1'b1,8'd0,"R8"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd900, 16'd0,   16'd922, 1'b1,1'b0,8'd0,"R3"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd500, 16'd0,   16'd922, 1'b1,1'b0,8'd1,"R7"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd500, 16'd0,   16'd922, 1'b1,1'b0,8'd2,"R5"},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'd0,   16'd922, 16'd922, 1'b0,1'b0,8'd2,"R4"},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'd0,   16'd0,   16'd922, 1'b0,1'b0,8'd2,"R6"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd1200,16'd0,   16'd922, 1'b1,1'b0,8'd3,"R7"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd922, 16'd922, 1'b0,1'b1,8'd3,"R4"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd0,   16'd0,   16'd922, 1'b1,1'b0,8'd4,"R6"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd100, 16'd922, 1'b1,1'b0,8'd4,"R4"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd922, 16'd922, 1'b0,1'b1,8'd4,"R4"},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd0,   16'd0,   16'd922, 1'b0,1'b0,8'd4,"R6"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd922, 16'd922, 1'b0,1'b1,8'd4,"R4"},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'd0,   16'd0,   16'd922, 1'b0,1'b1,8'd4,"R8"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,16'd1200,16'd0,   16'd1200,1'b1,1'b0,8'd0,"R2"},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,16'd0,   16'd1200,16'd1200,1'b1,1'b0,8'd1,"R9"}
  };

  logic        clk = 1'b0;
  logic        rst_n, chg_ok, dsg_go, empty_hit, temp_ok, sdr_ok;
  logic [15:0] prog_cap, meas_cap, avail_cap, learned_cap;
  logic        chg_flag, qual_flag;
  logic [7:0]  miss_cnt;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cap_learn uut (
    .clk(clk), .rst_n(rst_n), .prog_cap(prog_cap), .meas_cap(meas_cap),
    .avail_cap(avail_cap), .chg_ok(chg_ok), .dsg_go(dsg_go),
    .empty_hit(empty_hit), .temp_ok(temp_ok), .sdr_ok(sdr_ok),
    .learned_cap(learned_cap), .chg_flag(chg_flag), .qual_flag(qual_flag),
    .miss_cnt(miss_cnt)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic r, input logic vc, input logic ds,
                       input logic eod, input logic tok, input logic sok,
                       input logic [15:0] meas, input logic [15:0] avail);
    rst_n = r; chg_ok = vc; dsg_go = ds; empty_hit = eod;
    temp_ok = tok; sdr_ok = sok; meas_cap = meas; avail_cap = avail;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    prog_cap = 16'd1000;
    rst_n = 1'b0; chg_ok = 1'b0; dsg_go = 1'b0; empty_hit = 1'b0;
    temp_ok = 1'b1; sdr_ok = 1'b1; meas_cap = '0; avail_cap = '0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rst, VEC[i].vc, VEC[i].ds, VEC[i].eod,
            VEC[i].tok, VEC[i].sok, VEC[i].meas, VEC[i].avail);
      check(string'(VEC[i].tag), $sformatf("vec%0d cap", i), learned_cap, VEC[i].e_cap);
      check(string'(VEC[i].tag), $sformatf("vec%0d vq", i), 16'(chg_flag), 16'(VEC[i].e_vq));
      check(string'(VEC[i].tag), $sformatf("vec%0d dq", i), 16'(qual_flag), 16'(VEC[i].e_dq));
      check(string'(VEC[i].tag), $sformatf("vec%0d cnt", i), 16'(miss_cnt), 16'(VEC[i].e_cnt));
    end

    // R7: saturation at 255 after many charges without learning
    for (int k = 0; k < 260; k++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd50, 16'd0);
    check("R7", "cnt saturated", 16'(miss_cnt), 16'd255);
    check("R8", "cap unchanged by plain charges", learned_cap, 16'd1200);

    // R1: reset from a busy state with a new programmed value
    prog_cap = 16'd777;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0, 16'd0);
    check("R1", "reload cap", learned_cap, 16'd777);
    check("R1", "reset cnt", 16'(miss_cnt), 16'd0);
    check("R1", "reset vq", 16'(chg_flag), 16'd0);

    // R6: temperature fails on the same cycle as end of discharge
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd0, 16'd777);
    check("R4", "start from full", 16'(qual_flag), 16'd1);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'd0, 16'd0);
    check("R6", "eod with cold", 16'(qual_flag), 16'd0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd700, 16'd0);
    check("R2", "no learn when unqualified", learned_cap, 16'd777);
    check("R7", "miss counted", 16'(miss_cnt), 16'd1);

    // R9: empty_hit together with chg_ok is ignored
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd0, 16'd777);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'd760, 16'd0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd760, 16'd0);
    check("R9", "eod lost under charge", learned_cap, 16'd777);
    check("R9", "misses counted", 16'(miss_cnt), 16'd3);

    // R3: floor applied from 777 -> floor(777*241/256)=731
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd0, 16'd777);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd0, 16'd0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd10, 16'd0);
    check("R3", "floor limit", learned_cap, 16'd731);
    check("R2", "cnt cleared on learn", 16'(miss_cnt), 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule